// File: doc/BRIEF.md
# Descriptor-Driven DMA Loop Engine

This block is one DMA channel run by a transfer descriptor. The descriptor holds a source and a destination address. For each side it also holds a signed step added after every access, an access width and a wrap width. It further holds a byte count per minor loop, a major-loop iteration count and two signed end-of-major adjustments. The descriptor is latched from the `d_*` ports with a one-cycle `desc_load` pulse while the channel is idle.

Each accepted service request runs one minor loop on a simple memory master port. A hardware request is accepted only while the request enable is set. A software start is accepted regardless of the enable. Within a minor loop the engine gathers source reads into an eight-byte staging register, then scatters that data as destination writes. When the last minor loop of a major loop finishes, the engine does four things:
- adds the adjustments to both addresses,
- reloads the iteration count,
- raises done, and raises the interrupt if that option is set,
- clears the request enable if auto-disable is set.

A memory access is held on the port until `mem_ready` is high at a rising clock edge. Read data is lane-justified: byte i of `mem_rdata` is memory byte `mem_addr + i`, and the same holds for `mem_wdata`.

Top module: `dma_desc_engine`

## Requirements
- R1: After reset `busy`, `done`, `irq`, `err`, `req_en`, `start_pend` and `mem_req` are all 0.
- R2: A size code c (0, 1, 2, 3) means 2^c bytes (1, 2, 4, 8), set separately for each side. A minor loop repeats units of `max(src bytes, dst bytes)`. Each unit issues source reads until the unit is gathered, lowest address in the lowest byte, and then issues destination writes that carry those bytes in order. A loop always begins with a read, and a stalled access holds its address and direction.
- R3: After each access the 16-bit two's-complement step of that side is added to that side's address, so a negative step walks downward.
- R4: A nonzero wrap width w confines the step so that only address bits below w change; the bits from w up keep their value. A wrap width of 0 means no wrap.
- R5: Each service moves exactly `d_nbytes` bytes; a value of 0 means 2^32 bytes.
- R6: `cur_iter` (15 bits) loads from `d_iter`. It falls by one after each minor loop and reloads from the latched beginning count after the minor loop that ends the major loop, when it was 1.
- R7: At the end of a major loop the 32-bit two's-complement adjustments are added to both addresses, after the final step.
- R8: A `sw_start` pulse sets `start_pend`, which clears when the service is accepted, even with `req_en` low. `hw_req` is accepted only while `req_en` is 1.
- R9: The end of a major loop sets `done`, sets `irq` if `d_int_major` was latched as 1 (cleared by `irq_ack`), and clears `req_en` if `d_auto_dis` was latched as 1.
- R10: `busy` is 1 from the cycle after a service is accepted until its minor loop's last write completes.
- R11: `en_set` sets `req_en` and clears `done`; `en_clr` clears `req_en`.
- R12: A service whose byte count is not a multiple of the unit size sets `err`, makes no memory access and leaves `cur_iter` and both addresses unchanged; `desc_load` clears `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_load | input | 1 | Latch the descriptor inputs (idle only) |
| d_src_addr | input | AW | Source start address |
| d_dst_addr | input | AW | Destination start address |
| d_src_off | input | OFF_W | Signed source step |
| d_dst_off | input | OFF_W | Signed destination step |
| d_src_size | input | 2 | Source access size code |
| d_dst_size | input | 2 | Destination access size code |
| d_src_wrap | input | 5 | Source wrap width |
| d_dst_wrap | input | 5 | Destination wrap width |
| d_nbytes | input | NBYTE_W | Bytes per minor loop (0 = 2^32) |
| d_iter | input | ITER_W | Major-loop iteration count |
| d_src_last | input | AW | Signed source end adjustment |
| d_dst_last | input | AW | Signed destination end adjustment |
| d_int_major | input | 1 | Interrupt at end of major loop |
| d_auto_dis | input | 1 | Clear request enable at end of major loop |
| en_set | input | 1 | Set request enable, clear done |
| en_clr | input | 1 | Clear request enable |
| sw_start | input | 1 | Software service request pulse |
| hw_req | input | 1 | Hardware service request |
| irq_ack | input | 1 | Clear interrupt |
| mem_req | output | 1 | Memory access valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Access address |
| mem_size | output | 2 | Access size code |
| mem_wdata | output | DW | Write data, lane-justified |
| mem_rdata | input | DW | Read data, lane-justified |
| mem_ready | input | 1 | Access completes at this edge |
| busy | output | 1 | Minor loop in progress |
| done | output | 1 | Major loop finished |
| irq | output | 1 | Interrupt |
| err | output | 1 | Byte count misfit |
| req_en | output | 1 | Hardware request enable |
| start_pend | output | 1 | Software start pending |
| cur_iter | output | ITER_W | Current iteration count |
| src_addr | output | AW | Current source address |
| dst_addr | output | AW | Current destination address |

## Verification
The hardest case to reach from the ports is a gather or scatter unit interrupted by memory stalls at arbitrary points. In that case the staging offsets, the address steps and the ring-buffer wrap must all stay aligned, and then the end-of-major adjustment must land on top of the final step. The bench drives `mem_ready` from a free-running pseudo-random sequence, so stalls fall on every phase of a unit. It runs narrow-to-wide, wide-to-narrow, negative-step and wrapped transfers, and a scoreboard predicts every write address, size and byte. The 2^32-byte count cannot finish in a run, so it is shown by the loop still running with no error long after any programmed count would have ended.

// File: rtl/dma_loop_pkg.sv
package dma_loop_pkg;

   // Widest single access in bytes and the width of a byte offset into it.
   localparam int ACC_BYTES = 8;
   localparam int ACC_OFS_W = 4;
   localparam int WRAP_W    = 5;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_READ  = 2'd1,
      ST_WRITE = 2'd2
   } loop_state_e;

   typedef struct packed {
      logic [1:0]        size;
      logic [WRAP_W-1:0] wrap;
   } side_attr_t;

   function automatic logic [ACC_OFS_W-1:0] code_to_bytes(input logic [1:0] code);
      return ACC_OFS_W'(1) << code;
   endfunction

endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
   parameter int AW    = 32,
   parameter int OFF_W = 16,
   parameter int MW    = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [AW-1:0]    load_val,
   input  logic             step,
   input  logic [OFF_W-1:0] offset,
   input  logic [MW-1:0]    wrap_bits,
   input  logic             adjust,
   input  logic [AW-1:0]    adjust_val,
   output logic [AW-1:0]    addr
);
   localparam logic [AW-1:0] ONE = AW'(1);

   logic [AW-1:0] off_ext, sum, mask, stepped, after_step, nxt;

   always_comb begin
      off_ext    = {{(AW-OFF_W){offset[OFF_W-1]}}, offset};
      sum        = addr + off_ext;
      mask       = (wrap_bits == '0) ? '1 : ((ONE << wrap_bits) - ONE);
      stepped    = (addr & ~mask) | (sum & mask);
      after_step = step ? stepped : addr;
      nxt        = adjust ? (after_step + adjust_val) : after_step;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    addr <= '0;
      else if (load) addr <= load_val;
      else           addr <= nxt;
   end
endmodule

// File: rtl/dma_stage_buf.sv
module dma_stage_buf #(
   parameter int NB    = 8,
   parameter int OFS_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic [8*NB-1:0]   rd_data,
   input  logic [OFS_W-1:0]  put_ofs,
   input  logic [OFS_W-1:0]  put_len,
   input  logic [OFS_W-1:0]  take_ofs,
   output logic [8*NB-1:0]   take_data
);
   logic [8*NB-1:0] stage_q;
   logic [8*NB-1:0] shifted;
   logic [OFS_W:0]  put_end;

   assign shifted   = rd_data << {put_ofs, 3'b000};
   assign put_end   = {1'b0, put_ofs} + {1'b0, put_len};
   assign take_data = stage_q >> {take_ofs, 3'b000};

   for (genvar b = 0; b < NB; b++) begin : g_lane
      logic hit;
      assign hit = capture && ((OFS_W+1)'(b) >= {1'b0, put_ofs}) && ((OFS_W+1)'(b) < put_end);
      always_ff @(posedge clk) begin
         if (!rst_n)   stage_q[8*b +: 8] <= '0;
         else if (hit) stage_q[8*b +: 8] <= shifted[8*b +: 8];
      end
   end
endmodule

// File: rtl/dma_major_ctr.sv
module dma_major_ctr #(
   parameter int ITER_W = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ITER_W-1:0] begin_val,
   input  logic              minor_end,
   output logic [ITER_W-1:0] cur,
   output logic              final_pass
);
   assign final_pass = (cur <= ITER_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n)          cur <= '0;
      else if (load)       cur <= begin_val;
      else if (minor_end)  cur <= final_pass ? begin_val : cur - ITER_W'(1);
   end
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
   import dma_loop_pkg::*;
#(
   parameter int NBYTE_W = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 desc_load,
   input  logic                 en_set,
   input  logic                 en_clr,
   input  logic                 sw_start,
   input  logic                 hw_req,
   input  logic                 irq_ack,
   input  logic [NBYTE_W-1:0]   nbytes,
   input  logic [1:0]           src_size,
   input  logic [1:0]           dst_size,
   input  logic                 int_major,
   input  logic                 auto_dis,
   input  logic                 mem_ready,
   input  logic                 final_pass,
   output logic                 mem_req,
   output logic                 mem_we,
   output logic                 src_step,
   output logic                 dst_step,
   output logic                 major_end,
   output logic                 minor_end,
   output logic                 capture,
   output logic [ACC_OFS_W-1:0] put_ofs,
   output logic [ACC_OFS_W-1:0] put_len,
   output logic [ACC_OFS_W-1:0] take_ofs,
   output logic                 busy,
   output logic                 done,
   output logic                 irq,
   output logic                 err,
   output logic                 req_en,
   output logic                 start_pend
);
   localparam int RW = NBYTE_W + 1;

   loop_state_e          state_q;
   logic [RW-1:0]        remain_q;
   logic [ACC_OFS_W-1:0] fill_q, drain_q;
   logic [ACC_OFS_W-1:0] sbytes, dbytes, unit;
   logic [RW-1:0]        unit_w, remain_load;
   logic                 want, misfit, rd_fire, wr_fire, rd_last, wr_last;

   always_comb begin
      sbytes      = code_to_bytes(src_size);
      dbytes      = code_to_bytes(dst_size);
      unit        = (sbytes > dbytes) ? sbytes : dbytes;
      unit_w      = {{(RW-ACC_OFS_W){1'b0}}, unit};
      remain_load = (nbytes == '0) ? {1'b1, {NBYTE_W{1'b0}}} : {1'b0, nbytes};
      misfit      = (nbytes[ACC_OFS_W-1:0] & (unit - ACC_OFS_W'(1))) != '0;
      want        = (state_q == ST_IDLE) && (start_pend || (req_en && hw_req));
      rd_fire     = (state_q == ST_READ)  && mem_ready;
      wr_fire     = (state_q == ST_WRITE) && mem_ready;
      rd_last     = (fill_q + sbytes) == unit;
      wr_last     = (drain_q + dbytes) == unit;
      minor_end   = wr_fire && wr_last && (remain_q == unit_w);
      major_end   = minor_end && final_pass;
   end

   assign mem_req  = (state_q != ST_IDLE);
   assign mem_we   = (state_q == ST_WRITE);
   assign busy     = (state_q != ST_IDLE);
   assign src_step = rd_fire;
   assign dst_step = wr_fire;
   assign capture  = rd_fire;
   assign put_ofs  = fill_q;
   assign put_len  = sbytes;
   assign take_ofs = drain_q;

   // Minor-loop sequencer: gather one unit, scatter it, repeat.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         remain_q <= '0;
         fill_q   <= '0;
         drain_q  <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (want && !misfit) begin
                  state_q  <= ST_READ;
                  remain_q <= remain_load;
                  fill_q   <= '0;
               end
            end
            ST_READ: begin
               if (rd_fire) begin
                  if (rd_last) begin
                     state_q <= ST_WRITE;
                     drain_q <= '0;
                     fill_q  <= '0;
                  end else begin
                     fill_q <= fill_q + sbytes;
                  end
               end
            end
            ST_WRITE: begin
               if (wr_fire) begin
                  if (wr_last) begin
                     remain_q <= remain_q - unit_w;
                     drain_q  <= '0;
                     state_q  <= (remain_q == unit_w) ? ST_IDLE : ST_READ;
                  end else begin
                     drain_q <= drain_q + dbytes;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // Channel flags.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_pend <= 1'b0;
         req_en     <= 1'b0;
         done       <= 1'b0;
         irq        <= 1'b0;
         err        <= 1'b0;
      end else begin
         start_pend <= sw_start || (start_pend && !want);
         if (en_set)                     req_en <= 1'b1;
         else if (en_clr)                req_en <= 1'b0;
         else if (major_end && auto_dis) req_en <= 1'b0;
         if (major_end)                  done <= 1'b1;
         else if (en_set)                done <= 1'b0;
         if (major_end && int_major)     irq <= 1'b1;
         else if (irq_ack)               irq <= 1'b0;
         if (want && misfit)             err <= 1'b1;
         else if (desc_load)             err <= 1'b0;
      end
   end
endmodule

// File: rtl/dma_desc_engine.sv
module dma_desc_engine
   import dma_loop_pkg::*;
#(
   parameter int AW      = 32,
   parameter int DW      = 64,
   parameter int OFF_W   = 16,
   parameter int NBYTE_W = 32,
   parameter int ITER_W  = 15
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               desc_load,
   input  logic [AW-1:0]      d_src_addr,
   input  logic [AW-1:0]      d_dst_addr,
   input  logic [OFF_W-1:0]   d_src_off,
   input  logic [OFF_W-1:0]   d_dst_off,
   input  logic [1:0]         d_src_size,
   input  logic [1:0]         d_dst_size,
   input  logic [WRAP_W-1:0]  d_src_wrap,
   input  logic [WRAP_W-1:0]  d_dst_wrap,
   input  logic [NBYTE_W-1:0] d_nbytes,
   input  logic [ITER_W-1:0]  d_iter,
   input  logic [AW-1:0]      d_src_last,
   input  logic [AW-1:0]      d_dst_last,
   input  logic               d_int_major,
   input  logic               d_auto_dis,
   input  logic               en_set,
   input  logic               en_clr,
   input  logic               sw_start,
   input  logic               hw_req,
   input  logic               irq_ack,
   output logic               mem_req,
   output logic               mem_we,
   output logic [AW-1:0]      mem_addr,
   output logic [1:0]         mem_size,
   output logic [DW-1:0]      mem_wdata,
   input  logic [DW-1:0]      mem_rdata,
   input  logic               mem_ready,
   output logic               busy,
   output logic               done,
   output logic               irq,
   output logic               err,
   output logic               req_en,
   output logic               start_pend,
   output logic [ITER_W-1:0]  cur_iter,
   output logic [AW-1:0]      src_addr,
   output logic [AW-1:0]      dst_addr
);
   localparam int NB = DW / 8;

   if (DW != 8 * ACC_BYTES) begin : g_bad_dw
      $error("dma_desc_engine: DW must equal the widest access (64 bits)");
   end
   if (AW <= OFF_W) begin : g_bad_aw
      $error("dma_desc_engine: AW must exceed OFF_W");
   end
   if (NBYTE_W < ACC_OFS_W) begin : g_bad_nb
      $error("dma_desc_engine: NBYTE_W too small");
   end
   if (ITER_W < 2) begin : g_bad_iter
      $error("dma_desc_engine: ITER_W too small");
   end

   // Latched descriptor.
   side_attr_t                src_attr_q, dst_attr_q;
   logic [1:0][OFF_W-1:0]     off_q;
   logic [1:0][AW-1:0]        last_q;
   logic [NBYTE_W-1:0]        nbytes_q;
   logic [ITER_W-1:0]         biter_q;
   logic                      int_major_q, auto_dis_q;
   logic [WRAP_W-1:0]         src_wrap_q, dst_wrap_q;
   logic                      load_ok;

   assign load_ok    = desc_load && !busy;
   assign src_wrap_q = src_attr_q.wrap;
   assign dst_wrap_q = dst_attr_q.wrap;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         src_attr_q  <= '0;
         dst_attr_q  <= '0;
         off_q       <= '0;
         last_q      <= '0;
         nbytes_q    <= '0;
         biter_q     <= '0;
         int_major_q <= 1'b0;
         auto_dis_q  <= 1'b0;
      end else if (load_ok) begin
         src_attr_q  <= '{size: d_src_size, wrap: d_src_wrap};
         dst_attr_q  <= '{size: d_dst_size, wrap: d_dst_wrap};
         off_q       <= {d_dst_off, d_src_off};
         last_q      <= {d_dst_last, d_src_last};
         nbytes_q    <= d_nbytes;
         biter_q     <= d_iter;
         int_major_q <= d_int_major;
         auto_dis_q  <= d_auto_dis;
      end
   end

   // Control.
   logic                 src_step, dst_step, major_end, minor_end, capture, final_pass;
   logic [ACC_OFS_W-1:0] put_ofs, put_len, take_ofs;

   dma_chan_ctrl #(.NBYTE_W(NBYTE_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .desc_load  (desc_load),
      .en_set     (en_set),
      .en_clr     (en_clr),
      .sw_start   (sw_start),
      .hw_req     (hw_req),
      .irq_ack    (irq_ack),
      .nbytes     (nbytes_q),
      .src_size   (src_attr_q.size),
      .dst_size   (dst_attr_q.size),
      .int_major  (int_major_q),
      .auto_dis   (auto_dis_q),
      .mem_ready  (mem_ready),
      .final_pass (final_pass),
      .mem_req    (mem_req),
      .mem_we     (mem_we),
      .src_step   (src_step),
      .dst_step   (dst_step),
      .major_end  (major_end),
      .minor_end  (minor_end),
      .capture    (capture),
      .put_ofs    (put_ofs),
      .put_len    (put_len),
      .take_ofs   (take_ofs),
      .busy       (busy),
      .done       (done),
      .irq        (irq),
      .err        (err),
      .req_en     (req_en),
      .start_pend (start_pend)
   );

   dma_major_ctr #(.ITER_W(ITER_W)) u_major (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load_ok),
      .begin_val  (load_ok ? d_iter : biter_q),
      .minor_end  (minor_end),
      .cur        (cur_iter),
      .final_pass (final_pass)
   );

   // Address generators, index 0 = source, 1 = destination.
   logic [1:0][AW-1:0]     side_addr, side_start;
   logic [1:0][WRAP_W-1:0] side_wrap;
   logic [1:0]             side_step;

   assign side_start = {d_dst_addr, d_src_addr};
   assign side_wrap  = {dst_attr_q.wrap, src_attr_q.wrap};
   assign side_step  = {dst_step, src_step};

   for (genvar k = 0; k < 2; k++) begin : g_side
      dma_addr_step #(.AW(AW), .OFF_W(OFF_W), .MW(WRAP_W)) u_step (
         .clk        (clk),
         .rst_n      (rst_n),
         .load       (load_ok),
         .load_val   (side_start[k]),
         .step       (side_step[k]),
         .offset     (off_q[k]),
         .wrap_bits  (side_wrap[k]),
         .adjust     (major_end),
         .adjust_val (last_q[k]),
         .addr       (side_addr[k])
      );
   end

   assign src_addr = side_addr[0];
   assign dst_addr = side_addr[1];

   dma_stage_buf #(.NB(NB), .OFS_W(ACC_OFS_W)) u_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .capture   (capture),
      .rd_data   (mem_rdata),
      .put_ofs   (put_ofs),
      .put_len   (put_len),
      .take_ofs  (take_ofs),
      .take_data (mem_wdata)
   );

   assign mem_addr = mem_we ? dst_addr : src_addr;
   assign mem_size = mem_we ? dst_attr_q.size : src_attr_q.size;
endmodule

// File: rtl/dma_desc_engine_chk.sv
module dma_desc_engine_chk #(
   parameter int AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          sw_start,
   input logic          en_set,
   input logic          busy,
   input logic          done,
   input logic          irq,
   input logic          err,
   input logic          start_pend,
   input logic          mem_req,
   input logic          mem_we,
   input logic          mem_ready,
   input logic [AW-1:0] mem_addr,
   input logic [AW-1:0] src_addr,
   input logic [AW-1:0] dst_addr,
   input logic [4:0]    src_wrap_q,
   input logic [4:0]    dst_wrap_q
);
   localparam logic [AW-1:0] ONE = AW'(1);

   logic [AW-1:0] src_keep, dst_keep;
   assign src_keep = ~((ONE << src_wrap_q) - ONE);
   assign dst_keep = ~((ONE << dst_wrap_q) - ONE);

   AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R2
   AST_READ_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !mem_we); // R2
   AST_SRC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      busy && $past(busy) && (src_wrap_q != '0) |-> ((src_addr ^ $past(src_addr)) & src_keep) == '0); // R4
   AST_DST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      busy && $past(busy) && (dst_wrap_q != '0) |-> ((dst_addr ^ $past(dst_addr)) & dst_keep) == '0); // R4
   AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) && !$past(sw_start) |-> !start_pend); // R8
   AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> !busy && $past(busy)); // R9
   AST_IRQ_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> done); // R9
   AST_ENABLE_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      en_set && !busy |=> !done); // R11
   AST_ERR_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> !busy && !mem_req); // R12
endmodule

bind dma_desc_engine dma_desc_engine_chk #(.AW(AW)) u_chk (.*);

// File: tb/test_dma_desc_engine.sv
module test_dma_desc_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        desc_load = 0, en_set = 0, en_clr = 0, sw_start = 0, hw_req = 0, irq_ack = 0;
   logic [31:0] d_src_addr = 0, d_dst_addr = 0, d_src_last = 0, d_dst_last = 0, d_nbytes = 0;
   logic [15:0] d_src_off = 0, d_dst_off = 0;
   logic [1:0]  d_src_size = 0, d_dst_size = 0;
   logic [4:0]  d_src_wrap = 0, d_dst_wrap = 0;
   logic [14:0] d_iter = 0;
   logic        d_int_major = 0, d_auto_dis = 0;
   logic        mem_req, mem_we, mem_ready, busy, done, irq, err, req_en, start_pend;
   logic [31:0] mem_addr, src_addr, dst_addr;
   logic [1:0]  mem_size;
   logic [63:0] mem_wdata, mem_rdata;
   logic [14:0] cur_iter;

   always #4 clk = ~clk;

   dma_desc_engine i_dma_desc_engine (.*);

   int checks = 0, errors = 0;
   bit sb_on = 1'b1;

   typedef struct {logic [31:0] a; logic [1:0] s; logic [63:0] d;} wr_item_t;
   wr_item_t exp_q[$];

   logic [7:0] mem [256];
   logic [7:0] lfsr;

   function automatic logic [7:0] pat(logic [31:0] a);
      return 8'(a[7:0] * 8'd37 + 8'd11);
   endfunction

   function automatic logic [31:0] stepa(logic [31:0] a, logic [15:0] off, logic [4:0] w);
      logic [31:0] s, m;
      s = a + {{16{off[15]}}, off};
      m = (w == 0) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
      return (a & ~m) | (s & m);
   endfunction

   task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Memory model: pseudo-random ready, lane-justified data.
   always @(posedge clk) lfsr <= !rst_n ? 8'hA5 : {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
   assign mem_ready = lfsr[0] | lfsr[1];
   always_comb for (int i = 0; i < 8; i++) mem_rdata[8*i +: 8] = mem[8'(mem_addr[7:0] + 8'(i))];

   // Scoreboard monitor.
   always @(negedge clk) begin
      if (rst_n && mem_req && mem_we && mem_ready) begin
         for (int i = 0; i < (1 << mem_size); i++) mem[8'(mem_addr[7:0] + 8'(i))] = mem_wdata[8*i +: 8];
         if (sb_on) begin
            if (exp_q.size() == 0) chk(1'b0, "R2", "unexpected write", 64'(mem_addr), 0);
            else begin
               wr_item_t e;
               logic [63:0] m;
               e = exp_q.pop_front();
               m = (e.s == 2'd3) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (8 << e.s)) - 64'd1);
               chk(mem_addr == e.a, "R3", "write address", 64'(mem_addr), 64'(e.a));
               chk(mem_size == e.s, "R2", "write size", 64'(mem_size), 64'(e.s));
               chk((mem_wdata & m) == (e.d & m), "R2", "write data", mem_wdata & m, e.d & m);
            end
         end
      end
   end

   // Reference model state.
   logic [31:0] m_src, m_dst;
   logic [14:0] m_cur, m_beg;

   task automatic load_desc(logic [31:0] sa, da, logic [15:0] so, dof, logic [1:0] ss, ds,
                            logic [4:0] sw, dw, logic [31:0] nb, logic [14:0] it,
                            logic [31:0] sl, dl, logic im, ad);
      @(negedge clk);
      d_src_addr = sa; d_dst_addr = da; d_src_off = so; d_dst_off = dof;
      d_src_size = ss; d_dst_size = ds; d_src_wrap = sw; d_dst_wrap = dw;
      d_nbytes = nb; d_iter = it; d_src_last = sl; d_dst_last = dl;
      d_int_major = im; d_auto_dis = ad; desc_load = 1;
      @(negedge clk); desc_load = 0;
      m_src = sa; m_dst = da; m_cur = it; m_beg = it;
   endtask

   task automatic predict_minor();
      int sb, db, unit;
      logic [7:0] st [8];
      sb = 1 << d_src_size; db = 1 << d_dst_size; unit = (sb > db) ? sb : db;
      for (int p = 0; p < int'(d_nbytes) / unit; p++) begin
         for (int r = 0; r < unit / sb; r++) begin
            for (int i = 0; i < sb; i++) st[r*sb+i] = pat(m_src + 32'(i));
            m_src = stepa(m_src, d_src_off, d_src_wrap);
         end
         for (int w = 0; w < unit / db; w++) begin
            wr_item_t e;
            e.a = m_dst; e.s = d_dst_size; e.d = '0;
            for (int i = 0; i < db; i++) e.d[8*i +: 8] = st[w*db+i];
            exp_q.push_back(e);
            m_dst = stepa(m_dst, d_dst_off, d_dst_wrap);
         end
      end
      if (m_cur <= 1) begin
         m_src = m_src + d_src_last; m_dst = m_dst + d_dst_last; m_cur = m_beg;
      end else m_cur = m_cur - 1;
   endtask

   task automatic service(bit by_hw, string req);
      predict_minor();
      @(negedge clk);
      if (by_hw) begin hw_req = 1; @(negedge clk); hw_req = 0; end
      else begin
         sw_start = 1; @(negedge clk); sw_start = 0;
         chk(start_pend == 1, "R8", "start pending", 64'(start_pend), 1);
         @(negedge clk);
         chk(start_pend == 0, "R8", "start cleared on accept", 64'(start_pend), 0);
      end
      chk(busy == 1, "R10", "busy after accept", 64'(busy), 1);
      while (busy) @(negedge clk);
      chk(exp_q.size() == 0, req, "writes outstanding", 64'(exp_q.size()), 0);
      chk(cur_iter == m_cur, "R6", "current count", 64'(cur_iter), 64'(m_cur));
      chk(src_addr == m_src, req, "source address", 64'(src_addr), 64'(m_src));
      chk(dst_addr == m_dst, req, "destination address", 64'(dst_addr), 64'(m_dst));
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      bit seen;
      for (int i = 0; i < 256; i++) mem[i] = pat(32'(i));
      repeat (3) @(negedge clk);
      // R1: reset state
      chk({busy, done, irq, err, req_en, start_pend, mem_req} == 7'b0, "R1", "reset flags",
          64'({busy, done, irq, err, req_en, start_pend, mem_req}), 0);
      rst_n = 1;

      // R6 R7 R9: 32-bit copy, three minor loops by software start, wrapping back with adjustments
      load_desc(32'h1000, 32'h1080, 16'd4, 16'd4, 2, 2, 0, 0, 8, 3, -32'sd24, -32'sd24, 1, 0);
      service(0, "R3"); service(0, "R3");
      chk(done == 0, "R9", "done before end", 64'(done), 0);
      service(0, "R7");
      chk(src_addr == 32'h1000, "R7", "source rewound", 64'(src_addr), 64'h1000);
      chk(done == 1 && irq == 1, "R9", "done and irq", 64'({done, irq}), 3);
      @(negedge clk); irq_ack = 1; @(negedge clk); irq_ack = 0;
      chk(irq == 0, "R9", "irq ack", 64'(irq), 0);

      // R2: narrow source gathered into wide writes, and wide reads scattered
      load_desc(32'h0010, 32'h0090, 16'd1, 16'd4, 0, 2, 0, 0, 8, 1, 0, 0, 0, 0);
      service(0, "R2");
      load_desc(32'h0030, 32'h00C0, 16'd8, 16'd2, 3, 1, 0, 0, 16, 1, 0, 0, 0, 0);
      service(0, "R2");

      // R3: negative steps
      load_desc(32'h003E, 32'h00FE, -16'sd2, -16'sd2, 1, 1, 0, 0, 6, 1, 0, 0, 0, 0);
      service(0, "R3");

      // R4: 8-byte ring on the source
      load_desc(32'h0020, 32'h0080, 16'd4, 16'd4, 2, 2, 3, 0, 16, 1, 0, 0, 0, 0);
      service(0, "R4");
      chk(src_addr == 32'h0020, "R4", "ring source end", 64'(src_addr), 64'h20);

      // R8: hardware request ignored while disabled
      load_desc(32'h0000, 32'h00A0, 16'd1, 16'd1, 0, 0, 0, 0, 2, 2, 0, 0, 0, 1);
      seen = 0;
      @(negedge clk); hw_req = 1; @(negedge clk); hw_req = 0;
      repeat (4) begin @(negedge clk); seen |= busy; end
      chk(!seen && cur_iter == 2, "R8", "hw request without enable", 64'({seen, cur_iter}), 2);

      // R11 R9: enable clears done; auto-disable at end of major loop
      @(negedge clk); en_set = 1; @(negedge clk); en_set = 0;
      chk(req_en == 1 && done == 0, "R11", "enable set clears done", 64'({req_en, done}), 2);
      service(1, "R8");
      chk(req_en == 1, "R9", "still enabled mid-major", 64'(req_en), 1);
      service(1, "R9");
      chk(req_en == 0 && done == 1 && irq == 0, "R9", "auto disable, no irq",
          64'({req_en, done, irq}), 2);
      @(negedge clk); en_set = 1; @(negedge clk); en_set = 0;
      @(negedge clk); en_clr = 1; @(negedge clk); en_clr = 0;
      chk(req_en == 0, "R11", "enable clear", 64'(req_en), 0);

      // R12: byte count misfit
      load_desc(32'h0000, 32'h00B0, 16'd4, 16'd4, 2, 2, 0, 0, 6, 4, 0, 0, 0, 0);
      seen = 0;
      @(negedge clk); sw_start = 1; @(negedge clk); sw_start = 0;
      repeat (4) begin @(negedge clk); seen |= mem_req; end
      chk(err == 1 && !seen, "R12", "misfit error, no access", 64'({err, seen}), 2);
      chk(cur_iter == 4 && src_addr == 0 && dst_addr == 32'hB0, "R12", "state unchanged",
          64'({cur_iter, src_addr[7:0], dst_addr[7:0]}), 64'({15'd4, 8'h00, 8'hB0}));
      load_desc(32'h0000, 32'h00B0, 16'd4, 16'd4, 2, 2, 0, 0, 8, 1, 0, 0, 0, 0);
      chk(err == 0, "R12", "load clears error", 64'(err), 0);

      // R5: zero count means 2^32 bytes, still running long after
      sb_on = 0;
      load_desc(32'h0000, 32'h0080, 16'd8, 16'd8, 3, 3, 6, 6, 0, 1, 0, 0, 0, 0);
      @(negedge clk); sw_start = 1; @(negedge clk); sw_start = 0;
      repeat (200) @(negedge clk);
      chk(busy == 1 && err == 0, "R5", "zero count keeps running", 64'({busy, err}), 2);
      rst_n = 0; repeat (2) @(negedge clk);
      chk(busy == 0 && mem_req == 0, "R1", "reset stops loop", 64'({busy, mem_req}), 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule